// File: doc/BRIEF.md
# Bit-Serial Host Register Port

This block gives a host a one-wire path into a 47-bit control word and out of a 12-bit status word. Between the data pin and those registers sits a 59-bit transfer register. Its bits 0 to 46 map to the control word and bits 47 to 58 map to the status word. Every host access is one active-low chip-select pulse. The address bit and the read/write bit select one of four commands: shift a bit in, read a bit out, commit the control word, or arm status capture.

All host inputs pass through a two-flop synchronizer into the pixel clock domain, and the chip-select edges are detected there. A write sends the 47 control bits most significant first, then commits them with a separate pulse. A read always starts at bit 58. The bits read out are rotated back into the low end of the transfer register, so a full read leaves the contents as they were and can be repeated.

Top module: `serial_ctrl_port`

## Requirements
- R1: The command is taken from {a0_i, rw_i} on the falling edge of cs_ni and acted on at its rising edge. The codes are 00 = shift in, 01 = read, 10 = commit, 11 = arm status capture.
- R2: A shift-in command moves the transfer register up one place and puts sd_i into bit 0. After 47 shift-ins, the first bit sent sits in bit 46.
- R3: During a read, sd_o presents bit 58. At the rising edge the register rotates up one place and bit 58 re-enters at bit 0. Two back-to-back sets of 59 reads return the same sequence.
- R4: ctrl_o takes bits 46:0 of the transfer register only after a commit pulse ends. Shift-in, read and status commands leave ctrl_o unchanged.
- R5: Once the status command completes, bits 58:47 are reloaded from status_i on every clock, with status_i[11] going to bit 58. This stops at the next falling edge of cs_ni, and the last captured value is kept.
- R6: sd_oe_o is high only while a read command is active and cs_ni is low. It is low while cs_ni is high and for every other command.
- R7: A one-cycle agc_done_i pulse clears ctrl_o[25] and leaves the other control bits unchanged.
- R8: After reset, ctrl_o holds the default word 47'h0000_4000_0001, the transfer register is all zeros and sd_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Host strobe, active low |
| a0_i | input | 1 | Address qualifier |
| rw_i | input | 1 | Read (1) / write (0) qualifier |
| sd_i | input | 1 | Serial data from the host |
| status_i | input | 12 | Live status word |
| agc_done_i | input | 1 | Pulse: gain adjustment finished |
| sd_o | output | 1 | Serial data to the host |
| sd_oe_o | output | 1 | Output enable for the data pin |
| ctrl_o | output | 47 | Committed control word |

## Verification
The properties assume that every low and every high phase of cs_ni lasts at least three pixel clocks. They also assume that a0_i, rw_i and sd_i stay stable across both chip-select edges; without this the synchronized edges could pair a command with the wrong qualifiers. The stimulus changes the qualifiers and data one clock before each falling edge and holds every phase for six clocks. Read-back values are predicted from a bench-side model of the transfer register that is updated only from the command sequence.

// File: rtl/shp_pkg.sv
package shp_pkg;
  typedef enum logic [1:0] {
    CMD_SHIFT  = 2'b00,
    CMD_READ   = 2'b01,
    CMD_COMMIT = 2'b10,
    CMD_STATUS = 2'b11
  } cmd_e;
endpackage

// File: rtl/shp_sync.sv
module shp_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/shp_cmd.sv
module shp_cmd
  import shp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_n_s_i,
  input  logic a0_s_i,
  input  logic rw_s_i,
  output logic shift_stb_o,
  output logic read_stb_o,
  output logic commit_stb_o,
  output logic status_stb_o,
  output logic status_mode_o,
  output logic oe_o
);
  logic cs_q, active_q, mode_q;
  cmd_e cmd_q;
  logic fall, rise, done;

  assign fall = cs_q & ~cs_n_s_i;
  assign rise = ~cs_q & cs_n_s_i;
  assign done = rise & active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q     <= 1'b1;
      active_q <= 1'b0;
      cmd_q    <= CMD_SHIFT;
      mode_q   <= 1'b0;
    end else begin
      cs_q <= cs_n_s_i;
      if (fall) begin
        cmd_q    <= cmd_e'({a0_s_i, rw_s_i});
        active_q <= 1'b1;
        mode_q   <= 1'b0;
      end else if (done) begin
        active_q <= 1'b0;
        if (cmd_q == CMD_STATUS) mode_q <= 1'b1;
      end
    end
  end

  assign shift_stb_o   = done & (cmd_q == CMD_SHIFT);
  assign read_stb_o    = done & (cmd_q == CMD_READ);
  assign commit_stb_o  = done & (cmd_q == CMD_COMMIT);
  assign status_stb_o  = done & (cmd_q == CMD_STATUS);
  assign status_mode_o = mode_q;
  // drive only while strobe low in the synchronized view
  assign oe_o          = active_q & (cmd_q == CMD_READ) & ~cs_n_s_i;
endmodule

// File: rtl/shp_shreg.sv
module shp_shreg #(
  parameter int SR_W   = 59,
  parameter int CTRL_W = 47,
  localparam int STAT_W = SR_W - CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_stb_i,
  input  logic              read_stb_i,
  input  logic              status_mode_i,
  input  logic              sd_i,
  input  logic [STAT_W-1:0] status_i,
  output logic [SR_W-1:0]   sr_o
);
  logic [SR_W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else if (shift_stb_i) begin
      sr_q <= {sr_q[SR_W-2:0], sd_i};
    end else if (read_stb_i) begin
      sr_q <= {sr_q[SR_W-2:0], sr_q[SR_W-1]};
    end else if (status_mode_i) begin
      sr_q[SR_W-1:CTRL_W] <= status_i;
    end
  end

  assign sr_o = sr_q;
endmodule

// File: rtl/shp_ctrl.sv
module shp_ctrl #(
  parameter int              CTRL_W   = 47,
  parameter int              AGC_BIT  = 25,
  parameter logic [CTRL_W-1:0] CTRL_RST = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_stb_i,
  input  logic [CTRL_W-1:0] word_i,
  input  logic              agc_done_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (commit_stb_i) begin
      ctrl_q <= word_i;
    end else if (agc_done_i) begin
      ctrl_q[AGC_BIT] <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port #(
  parameter int                SR_W     = 59,
  parameter int                CTRL_W   = 47,
  parameter int                AGC_BIT  = 25,
  parameter logic [CTRL_W-1:0] CTRL_RST = 47'h0000_4000_0001,
  localparam int               STAT_W   = SR_W - CTRL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              a0_i,
  input  logic              rw_i,
  input  logic              sd_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              agc_done_i,
  output logic              sd_o,
  output logic              sd_oe_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [3:0]      pins_s;
  logic            cs_s, a0_s, rw_s, sd_s;
  logic            shift_stb, read_stb, commit_stb, status_stb, status_mode, oe;
  logic [SR_W-1:0] sr;

  shp_sync #(.W(4), .RST_VAL(4'b1000)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, a0_i, rw_i, sd_i}),
    .q_o   (pins_s)
  );
  assign {cs_s, a0_s, rw_s, sd_s} = pins_s;

  shp_cmd u_cmd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_n_s_i     (cs_s),
    .a0_s_i       (a0_s),
    .rw_s_i       (rw_s),
    .shift_stb_o  (shift_stb),
    .read_stb_o   (read_stb),
    .commit_stb_o (commit_stb),
    .status_stb_o (status_stb),
    .status_mode_o(status_mode),
    .oe_o         (oe)
  );

  shp_shreg #(.SR_W(SR_W), .CTRL_W(CTRL_W)) u_shreg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .shift_stb_i  (shift_stb),
    .read_stb_i   (read_stb),
    .status_mode_i(status_mode),
    .sd_i         (sd_s),
    .status_i     (status_i),
    .sr_o         (sr)
  );

  shp_ctrl #(.CTRL_W(CTRL_W), .AGC_BIT(AGC_BIT), .CTRL_RST(CTRL_RST)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .commit_stb_i(commit_stb),
    .word_i      (sr[CTRL_W-1:0]),
    .agc_done_i  (agc_done_i),
    .ctrl_o      (ctrl_o)
  );

  assign sd_oe_o = oe;
  assign sd_o    = oe ? sr[SR_W-1] : 1'b0;
endmodule

// File: rtl/serial_ctrl_port_chk.sv
module serial_ctrl_port_chk #(
  parameter int SR_W    = 59,
  parameter int CTRL_W  = 47,
  parameter int AGC_BIT = 25,
  localparam int STAT_W = SR_W - CTRL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic [STAT_W-1:0] status_i,
  input logic              agc_done_i,
  input logic              sd_oe_o,
  input logic [CTRL_W-1:0] ctrl_o,
  input logic              shift_stb,
  input logic              read_stb,
  input logic              commit_stb,
  input logic              status_stb,
  input logic              status_mode,
  input logic [SR_W-1:0]   sr
);
  AST_ONE_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({shift_stb, read_stb, commit_stb, status_stb})) else $error("one cmd"); // R1

  AST_SR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_stb && !read_stb && !status_mode |=> $stable(sr)) else $error("sr idle"); // R2

  AST_READ_ROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    read_stb |=> sr[0] == $past(sr[SR_W-1])) else $error("rotate"); // R3

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(commit_stb || agc_done_i)) else $error("ctrl hold"); // R4

  AST_STAT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_mode && !shift_stb && !read_stb |=> sr[SR_W-1:CTRL_W] == $past(status_i)) else $error("status"); // R5

  AST_OE_CS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_oe_o |-> !$past(cs_ni, 2)) else $error("oe"); // R6

  AST_AGC_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agc_done_i && !commit_stb |=> !ctrl_o[AGC_BIT]) else $error("agc"); // R7
endmodule

bind serial_ctrl_port serial_ctrl_port_chk #(.SR_W(SR_W), .CTRL_W(CTRL_W), .AGC_BIT(AGC_BIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_ni      (cs_ni),
  .status_i   (status_i),
  .agc_done_i (agc_done_i),
  .sd_oe_o    (sd_oe_o),
  .ctrl_o     (ctrl_o),
  .shift_stb  (shift_stb),
  .read_stb   (read_stb),
  .commit_stb (commit_stb),
  .status_stb (status_stb),
  .status_mode(status_mode),
  .sr         (sr)
);

// File: tb/serial_ctrl_port_tb_top.sv
module serial_ctrl_port_tb_top;
  localparam logic [46:0] DEF = 47'h0000_4000_0001;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, a0 = 1'b0, rw = 1'b0, sd = 1'b0, agc_done = 1'b0;
  logic [11:0] status = '0;
  logic sd_o, sd_oe_o;
  logic [46:0] ctrl_o;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [58:0] m = '0;
  logic [46:0] mid_ctrl;
  bit   exp_q[$];
  string req_q[$];
  event smp_ev;

  always #5 clk = ~clk;

  serial_ctrl_port dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_ni(cs_ni), .a0_i(a0), .rw_i(rw), .sd_i(sd),
    .status_i(status), .agc_done_i(agc_done), .sd_o(sd_o), .sd_oe_o(sd_oe_o), .ctrl_o(ctrl_o)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected read bits
  always @(smp_ev) begin
    bit e; string r;
    e = exp_q.pop_front();
    r = req_q.pop_front();
    check(sd_oe_o === 1'b1, r, {63'd0, sd_oe_o}, 64'd1);
    check(sd_o === e, r, {63'd0, sd_o}, {63'd0, e});
  end

  task automatic cs_cycle(input logic a, input logic w, input logic d, input string req);
    @(negedge clk);
    a0 = a; rw = w; sd = d;
    @(negedge clk);
    cs_ni = 1'b0;
    repeat (6) @(negedge clk);
    mid_ctrl = ctrl_o;
    if ({a, w} == 2'b01) begin
      exp_q.push_back(m[58]);
      req_q.push_back(req);
      ->smp_ev;
      m = {m[57:0], m[58]};
    end else begin
      check(sd_oe_o === 1'b0, "R6 non-read oe", {63'd0, sd_oe_o}, 64'd0);
      if ({a, w} == 2'b00) m = {m[57:0], d};
    end
    #1;
    cs_ni = 1'b1;
    repeat (6) @(negedge clk);
    check(sd_oe_o === 1'b0, "R6 cs high oe", {63'd0, sd_oe_o}, 64'd0);
  endtask

  task automatic write_word(input logic [46:0] w);
    for (int i = 46; i >= 0; i--) cs_cycle(1'b0, 1'b0, w[i], "R2");
  endtask

  task automatic commit(input logic [46:0] exp_new, input logic [46:0] exp_old);
    cs_cycle(1'b1, 1'b0, 1'b0, "R4");
    check(mid_ctrl === exp_old, "R4 ctrl before cs rise", {17'd0, mid_ctrl}, {17'd0, exp_old});
    check(ctrl_o === exp_new, "R4 ctrl after commit", {17'd0, ctrl_o}, {17'd0, exp_new});
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 59; i++) cs_cycle(1'b0, 1'b1, 1'b0, req);
  endtask

  initial begin
    logic [46:0] p1, p2;
    p1 = 47'h1234_5678_9ABC;
    p2 = 47'h0ACE_0F0F_3C3C | (47'h1 << 25);
    repeat (3) @(negedge clk);
    check(ctrl_o === DEF, "R8 ctrl default", {17'd0, ctrl_o}, {17'd0, DEF});
    check(sd_oe_o === 1'b0, "R8 oe reset", {63'd0, sd_oe_o}, 64'd0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(ctrl_o === DEF, "R8 ctrl after release", {17'd0, ctrl_o}, {17'd0, DEF});

    write_word(p1);
    check(ctrl_o === DEF, "R4 shift leaves ctrl", {17'd0, ctrl_o}, {17'd0, DEF});
    commit(p1, DEF); // R1 code 10
    read_all("R3 first read (R8 zero status)");
    read_all("R3 repeated read");
    check(ctrl_o === p1, "R4 read leaves ctrl", {17'd0, ctrl_o}, {17'd0, p1});

    status = 12'hA5C;
    cs_cycle(1'b1, 1'b1, 1'b0, "R5"); // R1 code 11
    repeat (4) @(negedge clk);
    m[58:47] = 12'hA5C;
    cs_cycle(1'b0, 1'b1, 1'b0, "R5 status bit");
    status = 12'h3F0; // capture has ended
    for (int i = 1; i < 59; i++) cs_cycle(1'b0, 1'b1, 1'b0, "R5 status held");
    check(ctrl_o === p1, "R4 status leaves ctrl", {17'd0, ctrl_o}, {17'd0, p1});

    write_word(p2);
    commit(p2, p1);
    @(negedge clk); agc_done = 1'b1;
    @(negedge clk); agc_done = 1'b0;
    @(negedge clk);
    check(ctrl_o === (p2 & ~(47'h1 << 25)), "R7 agc self clear", {17'd0, ctrl_o},
          {17'd0, p2 & ~(47'h1 << 25)});
    read_all("R1 R3 read after commit");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule